// File: doc/BRIEF.md
# Dual-Edge Phase Window Finder

This block finds a safe moment to pass information between two clock domains that come from one shared reference and run at a 20:21 frequency ratio. Twenty slow cycles span exactly the same time as twenty-one fast cycles. The slow domain drives a marker that flips on every slow rising edge. The fast domain samples that marker twice per cycle, once on the falling edge and once on the next rising edge, which doubles its effective sampling rate. A fast cycle whose two samples differ had the marker change during its second half. That gives the earlier sample about half a fast period of setup margin, so the cycle is a usable transfer slot.

The fast domain numbers its cycles 0 to 20 in a repeating pattern. It records which slots qualify over whole patterns, and it trusts the record only when two consecutive patterns agree. It then picks the middle qualifying slot, which also leaves hold margin. From that point on it raises a one-cycle transfer-enable strobe in that slot in every pattern. When the shared-reference lock input drops, the learned slot is discarded and learning starts again.

Top module: `phase_window_finder`

## Requirements
- R1: While the fast-domain reset is active, `locked`, `xferStrobe` and `slotIdx` are all zero.
- R2: A fast slot qualifies when the slow marker changes between the falling-edge sample in that fast cycle and the rising-edge sample that ends the cycle. The slot shown on `slotIdx` is always a qualifying slot.
- R3: Slot numbers count 0 to 20 and wrap. While `locked` is high, `xferStrobe` is high for exactly one fast cycle in every 21, always in the slot given by `slotIdx`.
- R4: Among the qualifying slots in ascending slot order, the chosen slot is the entry at position floor((n-1)/2), where n is the number of qualifying slots.
- R5: `locked` rises only after two consecutive complete 21-cycle patterns produce the same non-empty qualifying set. With the marker running, this happens within 90 fast cycles of `refLock` rising.
- R6: If a pattern contains no qualifying slot, `locked` stays low and observation starts over.
- R7: Within four fast cycles of `refLock` going low, `locked`, `xferStrobe` and `slotIdx` are all zero. They stay zero while `refLock` is low, and learning starts again once it returns high.
- R8: `slotIdx` does not change while `locked` stays high.
- R9: `xferStrobe` is never high while `locked` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fastClk | input | 1 | Fast-domain clock (21 cycles per pattern) |
| fastRst | input | 1 | Synchronous active-high reset, fast domain |
| slowClk | input | 1 | Slow-domain clock (20 cycles per pattern) |
| slowRst | input | 1 | Synchronous active-high reset, slow domain; holds the marker still |
| refLock | input | 1 | High while both clocks track the shared reference; synchronized internally |
| xferStrobe | output | 1 | One-cycle transfer enable in the chosen slot |
| slotIdx | output | 5 | Chosen slot number, zero when not locked |
| locked | output | 1 | High once a slot has been learned and confirmed |

## Verification
Several properties are checked on every fast cycle: strobes only while locked, exactly 21 cycles between strobes, a stable slot index, a slot counter that stays in range, no commit from an empty pattern, lock reached only from the confirming state, and clearing after loss of lock. Other properties depend on the real timing of the two clocks, so only the bench scenarios can show them. These are whether the chosen slot truly sits on a marker change in the second half of a fast cycle, and whether it is the middle of the qualifying set. The bench works these out from its own clock timing. It also shows that a frozen marker never lets the block lock, and that the block relearns after loss of lock.

// File: rtl/pwf_pkg.sv
package pwf_pkg;

  typedef enum logic [1:0] {
    OBS_FIRST   = 2'd0,
    OBS_CONFIRM = 2'd1,
    HOLD_LOCK   = 2'd2
  } finderState_t;

  typedef struct packed {
    logic loadRef;
    logic commit;
  } ctlStrobes_t;

endpackage

// File: rtl/pwf_datapath.sv
module pwf_datapath
  import pwf_pkg::*;
#(
  parameter int SLOTS = 21,
  parameter int IDX_W = 5
) (
  input  logic              fastClk,
  input  logic              fastRst,
  input  logic              slowClk,
  input  logic              slowRst,
  input  logic              clrLearn,
  input  ctlStrobes_t       ctl,
  input  logic              lockedState,
  output logic              wrap,
  output logic              periodZero,
  output logic              periodMatch,
  output logic              xferStrobe,
  output logic [IDX_W-1:0]  slotIdx
);

  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(SLOTS - 1);

  // slow domain: marker flips on every slow rising edge
  logic marker;
  always_ff @(posedge slowClk) begin
    if (slowRst) marker <= 1'b0;
    else         marker <= ~marker;
  end

  // fast domain: falling-edge sample
  logic fallSample;
  always_ff @(negedge fastClk) begin
    if (fastRst) fallSample <= 1'b0;
    else         fallSample <= marker;
  end

  // rising-edge sample paired with the falling sample of the same cycle
  logic             riseSample;
  logic             fallHold;
  logic [IDX_W-1:0] slotCnt;
  logic [IDX_W-1:0] prevSlot;
  logic             sampleValid;

  always_ff @(posedge fastClk) begin
    if (fastRst || clrLearn) begin
      riseSample  <= 1'b0;
      fallHold    <= 1'b0;
      slotCnt     <= '0;
      prevSlot    <= '0;
      sampleValid <= 1'b0;
    end else begin
      riseSample  <= marker;
      fallHold    <= fallSample;
      slotCnt     <= (slotCnt == LAST_SLOT) ? '0 : slotCnt + 1'b1;
      prevSlot    <= slotCnt;
      sampleValid <= 1'b1;
    end
  end

  logic qualPrev;
  assign qualPrev = riseSample ^ fallHold;

  // qualification masks
  logic [SLOTS-1:0] curMask;
  logic [SLOTS-1:0] refMask;
  logic [SLOTS-1:0] periodMask;

  always_comb begin
    periodMask           = curMask;
    periodMask[prevSlot] = qualPrev;
  end

  assign wrap        = sampleValid && (prevSlot == LAST_SLOT);
  assign periodZero  = (periodMask == '0);
  assign periodMatch = (periodMask == refMask);

  always_ff @(posedge fastClk) begin
    if (fastRst || clrLearn) begin
      curMask <= '0;
      refMask <= '0;
    end else begin
      if (sampleValid) curMask[prevSlot] <= qualPrev;
      if (ctl.loadRef) refMask <= periodMask;
    end
  end

  // middle-slot selection
  function automatic logic [IDX_W-1:0] pickMiddle(input logic [SLOTS-1:0] m);
    int total;
    int target;
    int seen;
    logic [IDX_W-1:0] res;
    total = 0;
    for (int i = 0; i < SLOTS; i++) if (m[i]) total++;
    target = (total - 1) / 2;
    seen   = 0;
    res    = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (m[i]) begin
        if (seen == target) res = IDX_W'(i);
        seen++;
      end
    end
    return res;
  endfunction

  logic [IDX_W-1:0] chosenSlot;
  always_ff @(posedge fastClk) begin
    if (fastRst || clrLearn) chosenSlot <= '0;
    else if (ctl.commit)     chosenSlot <= pickMiddle(periodMask);
  end

  assign slotIdx    = chosenSlot;
  assign xferStrobe = lockedState && (slotCnt == chosenSlot);

  // R3: slot counter stays inside the pattern
  a_r3_slot_range: assert property (@(posedge fastClk) disable iff (fastRst)
    slotCnt <= LAST_SLOT);

  // R6: a commit never comes from an empty pattern
  a_r6_commit_nonempty: assert property (@(posedge fastClk) disable iff (fastRst)
    ctl.commit |-> !periodZero);

endmodule

// File: rtl/pwf_control.sv
module pwf_control
  import pwf_pkg::*;
(
  input  logic        fastClk,
  input  logic        fastRst,
  input  logic        lockSync,
  input  logic        wrap,
  input  logic        periodZero,
  input  logic        periodMatch,
  output ctlStrobes_t ctl,
  output logic        lockedState
);

  finderState_t state;
  finderState_t nextState;

  always_comb begin
    ctl       = '0;
    nextState = state;
    unique case (state)
      OBS_FIRST: begin
        if (wrap) begin
          ctl.loadRef = 1'b1;
          if (!periodZero) nextState = OBS_CONFIRM;
        end
      end
      OBS_CONFIRM: begin
        if (wrap) begin
          if (periodMatch) begin
            ctl.commit = 1'b1;
            nextState  = HOLD_LOCK;
          end else begin
            ctl.loadRef = 1'b1;
            if (periodZero) nextState = OBS_FIRST;
          end
        end
      end
      HOLD_LOCK: nextState = HOLD_LOCK;
      default:   nextState = OBS_FIRST;
    endcase
    if (!lockSync) begin
      ctl       = '0;
      nextState = OBS_FIRST;
    end
  end

  always_ff @(posedge fastClk) begin
    if (fastRst) state <= OBS_FIRST;
    else         state <= nextState;
  end

  assign lockedState = (state == HOLD_LOCK);

  // R5: lock is entered only from the confirming observation
  a_r5_lock_after_confirm: assert property (@(posedge fastClk) disable iff (fastRst)
    $rose(lockedState) |-> $past(state) == OBS_CONFIRM);

endmodule

// File: rtl/phase_window_finder.sv
module phase_window_finder
  import pwf_pkg::*;
#(
  parameter int SLOTS       = 21,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(SLOTS)
) (
  input  logic             fastClk,
  input  logic             fastRst,
  input  logic             slowClk,
  input  logic             slowRst,
  input  logic             refLock,
  output logic             xferStrobe,
  output logic [IDX_W-1:0] slotIdx,
  output logic             locked
);

  localparam int GAP_W = IDX_W + 2;

  // synchronize the reference lock indication into the fast domain
  logic [SYNC_STAGES-1:0] lockChain;
  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge fastClk) begin
        if (fastRst) lockChain <= '0;
        else         lockChain <= refLock;
      end
    end else begin : g_sync_many
      always_ff @(posedge fastClk) begin
        if (fastRst) lockChain <= '0;
        else         lockChain <= {lockChain[SYNC_STAGES-2:0], refLock};
      end
    end
  endgenerate

  logic lockSync;
  assign lockSync = lockChain[SYNC_STAGES-1];

  ctlStrobes_t ctl;
  logic wrap, periodZero, periodMatch, lockedState;

  pwf_control u_control (
    .fastClk     (fastClk),
    .fastRst     (fastRst),
    .lockSync    (lockSync),
    .wrap        (wrap),
    .periodZero  (periodZero),
    .periodMatch (periodMatch),
    .ctl         (ctl),
    .lockedState (lockedState)
  );

  pwf_datapath #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_datapath (
    .fastClk     (fastClk),
    .fastRst     (fastRst),
    .slowClk     (slowClk),
    .slowRst     (slowRst),
    .clrLearn    (!lockSync),
    .ctl         (ctl),
    .lockedState (lockedState),
    .wrap        (wrap),
    .periodZero  (periodZero),
    .periodMatch (periodMatch),
    .xferStrobe  (xferStrobe),
    .slotIdx     (slotIdx)
  );

  assign locked = lockedState;

  // strobe spacing checker
  logic [GAP_W-1:0] gapCnt;
  logic             seenStrobe;
  always_ff @(posedge fastClk) begin
    if (fastRst || !locked) begin
      gapCnt     <= '0;
      seenStrobe <= 1'b0;
    end else if (xferStrobe) begin
      gapCnt     <= '0;
      seenStrobe <= 1'b1;
    end else begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  // R3: consecutive strobes are one pattern apart
  a_r3_strobe_spacing: assert property (@(posedge fastClk) disable iff (fastRst)
    (xferStrobe && seenStrobe) |-> gapCnt == GAP_W'(SLOTS - 1));

  // R9: no strobe without lock
  a_r9_strobe_needs_lock: assert property (@(posedge fastClk) disable iff (fastRst)
    xferStrobe |-> locked);

  // R8: slot index holds while locked
  a_r8_slot_stable: assert property (@(posedge fastClk) disable iff (fastRst)
    (locked && $past(locked)) |-> $stable(slotIdx));

  // R7: loss of reference lock clears the learned state
  a_r7_lock_loss_clears: assert property (@(posedge fastClk) disable iff (fastRst)
    !lockSync |=> (!locked && slotIdx == '0));

endmodule

// File: tb/phase_window_finder_tb.sv
`timescale 1ps/1ps
module phase_window_finder_tb;

  localparam longint FAST_P   = 5000;
  localparam longint SLOW_P   = 5250;
  localparam longint SLOW_OFF = 1060;
  localparam int     SLOTS    = 21;

  logic fastClk = 1'b0;
  logic slowClk = 1'b0;
  logic fastRst, slowRst, refLock;
  logic xferStrobe, locked;
  logic [4:0] slotIdx;

  int nChecks = 0;
  int nFails  = 0;
  longint lastRise = 0;

  always #2500 fastClk = ~fastClk;
  initial begin
    #(SLOW_OFF);
    forever begin
      slowClk = ~slowClk;
      #2625;
    end
  end

  always @(posedge fastClk) lastRise = $time;

  phase_window_finder u_dut (
    .fastClk    (fastClk),
    .fastRst    (fastRst),
    .slowClk    (slowClk),
    .slowRst    (slowRst),
    .refLock    (refLock),
    .xferStrobe (xferStrobe),
    .slotIdx    (slotIdx),
    .locked     (locked)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge fastClk);
  endtask

  // marker changes at every slow rising edge: SLOW_OFF + m*SLOW_P
  function automatic bit slotQualifies(input longint p);
    longint num, m, t;
    num = p + FAST_P / 2 - SLOW_OFF;
    m   = num / SLOW_P + ((num % SLOW_P) != 0 ? 1 : 0);
    t   = SLOW_OFF + m * SLOW_P;
    return (t < p + FAST_P);
  endfunction

  task automatic expectLock(input string tag, input int maxWait);
    int waited = 0;
    int strobes = 0;
    int gapBad = 0;
    int sinceLast = 0;
    int lockDrops = 0;
    int idxMoves = 0;
    longint firstStrobe = -1;
    logic [4:0] idx0;
    longint base;
    int n;
    int expMid;
    int seen;
    while (!locked && waited < maxWait) begin
      @(negedge fastClk);
      waited++;
    end
    check(locked, {"R5 lock reached ", tag}, locked, 1);
    idx0 = slotIdx;
    for (int c = 0; c < 5 * SLOTS; c++) begin
      @(negedge fastClk);
      if (!locked) lockDrops++;
      if (slotIdx != idx0) idxMoves++;
      if (xferStrobe) begin
        if (strobes > 0 && sinceLast != SLOTS) gapBad++;
        if (firstStrobe < 0) firstStrobe = lastRise;
        strobes++;
        sinceLast = 0;
      end
      sinceLast++;
    end
    check(lockDrops == 0, {"R8 lock held ", tag}, lockDrops, 0);
    check(idxMoves == 0, {"R8 slot stable ", tag}, idxMoves, 0);
    check(strobes == 5, {"R3 strobe count ", tag}, strobes, 5);
    check(gapBad == 0, {"R3 strobe spacing ", tag}, gapBad, 0);
    if (firstStrobe >= 0) begin
      check(slotQualifies(firstStrobe), {"R2 chosen slot qualifies ", tag}, 0, 1);
      base = firstStrobe - longint'(idx0) * FAST_P + SLOTS * FAST_P;
      n = 0;
      for (int j = 0; j < SLOTS; j++) if (slotQualifies(base + j * FAST_P)) n++;
      expMid = -1;
      seen = 0;
      for (int j = 0; j < SLOTS; j++) begin
        if (slotQualifies(base + j * FAST_P)) begin
          if (seen == (n - 1) / 2) expMid = j;
          seen++;
        end
      end
      check(int'(idx0) == expMid, {"R4 middle slot ", tag}, idx0, expMid);
    end
  endtask

  task automatic testReset();
    fastRst = 1'b1; slowRst = 1'b1; refLock = 1'b0;
    cycles(4);
    check(!locked, "R1 locked in reset", locked, 0);
    check(!xferStrobe, "R1 strobe in reset", xferStrobe, 0);
    check(slotIdx == 0, "R1 slot in reset", slotIdx, 0);
    fastRst = 1'b0; slowRst = 1'b0;
    cycles(30);
    check(!locked, "R7 no lock without reference", locked, 0);
  endtask

  task automatic testLearn();
    refLock = 1'b1;
    expectLock("first", 90);
  endtask

  task automatic testLockLoss();
    int bad = 0;
    refLock = 1'b0;
    cycles(4);
    check(!locked, "R7 locked cleared", locked, 0);
    check(slotIdx == 0, "R7 slot cleared", slotIdx, 0);
    for (int c = 0; c < 50; c++) begin
      @(negedge fastClk);
      if (xferStrobe || locked) bad++;
    end
    check(bad == 0, "R9 quiet while unlocked", bad, 0);
    refLock = 1'b1;
    expectLock("relearn", 90);
  endtask

  task automatic testNoQualify();
    int bad = 0;
    slowRst = 1'b1;
    refLock = 1'b0;
    cycles(4);
    refLock = 1'b1;
    for (int c = 0; c < 200; c++) begin
      @(negedge fastClk);
      if (locked || xferStrobe) bad++;
    end
    check(bad == 0, "R6 frozen marker never locks", bad, 0);
    slowRst = 1'b0;
    expectLock("after marker restart", 150);
  endtask

  initial begin
    #(64'd100_000_000);
    nFails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    testReset();
    testLearn();
    testLockLoss();
    testNoQualify();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule